// File: doc/BRIEF.md
# Power Average and Decimate Unit

This block measures the mean power of a complex baseband stream. Each accepted I/Q sample becomes an instantaneous power I²+Q². That value is scaled down by a programmable right shift and summed over blocks of M samples by an integrate-and-dump stage. Each completed block sum enters a four-entry history. After every M accepted samples the block emits one result: the sum of the newest N block sums, where N is a multiple between 1 and 4.

The averaging window is therefore always N×M samples. The coarse shift is meant to be set to ceil(log2(N×M)), so that the result stays at or below the power of a single sample. The accumulation paths are wide enough to hold the unshifted total anyway. The decimation ratio, the multiple and the shift are sampled only on a synchronous restart, which also clears all running state. Software can therefore stage new settings on the configuration pins at any time and apply them all at once.

Top module: `pwr_avg_dec`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_avg` is 0. The latched settings are M=1, N=1 and shift 0.
- R2: The power of an accepted sample is I²+Q², with `in_i` and `in_q` read as two's-complement values.
- R3: `cfg_dec_m` holds M−1, so 0 means M=1 and 4095 means M=4096. Exactly one result is produced for every M accepted samples.
- R4: Each power value is shifted right by the latched shift before it is summed. `cfg_shift` values of 15 act as 14.
- R5: `cfg_avg_n` holds N−1. A result is the sum of the newest N block sums, counting the block just finished. Block sums not yet collected since the last restart count as zero.
- R6: If the last sample of a block is accepted at clock edge e, then `out_valid` is high for the one cycle after edge e+1, and `out_avg` changes at that same edge. `out_avg` keeps its value until the next result.
- R7: Settings are captured only in a cycle with `restart` high. That cycle clears the integrator, the sample count, the history, the power stage, `out_avg` and `out_valid`, and it discards any sample offered in the same cycle.
- R8: The result never wraps. The full-scale input with M=4096, N=4 and shift 0 gives exactly 2^45.
- R9: Cycles with `in_valid` low do not change the integrator or the sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart; captures the settings |
| cfg_dec_m | input | 12 | Decimation ratio minus one |
| cfg_avg_n | input | 2 | Averaging multiple minus one |
| cfg_shift | input | 4 | Pre-attenuation shift (15 treated as 14) |
| in_valid | input | 1 | Sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Result strobe |
| out_avg | output | 46 | Averaged power result |

## Verification
The risky coincidence is a restart arriving in the same cycle that a block would complete, while a sample is also offered. The bench feeds a block up to its last sample and then raises `restart` together with `in_valid`. It expects no result in the following cycle, and it expects the next result to contain only power collected after the restart. A second coincidence is a block completing while the history is already full. The bench provokes it with long runs at N=4, where the oldest entry must drop out exactly when the newest enters. A behavioural model built on queues is compared against both outputs on every clock.

// File: rtl/pwr_avg_pkg.sv
package pwr_avg_pkg;
    localparam int CFG_M_W   = 12;
    localparam int CFG_N_W   = 2;
    localparam int CFG_SH_W  = 4;
    localparam int SHIFT_MAX = 14;
    localparam int HIST_DEPTH = 1 << CFG_N_W;

    typedef struct packed {
        logic [CFG_M_W-1:0]  m_minus1;
        logic [CFG_N_W-1:0]  n_minus1;
        logic [CFG_SH_W-1:0] shift;
    } avg_cfg_t;

    function automatic logic [CFG_SH_W-1:0] clamp_shift(input logic [CFG_SH_W-1:0] s);
        return (s > CFG_SH_W'(SHIFT_MAX)) ? CFG_SH_W'(SHIFT_MAX) : s;
    endfunction
endpackage

// File: rtl/pwr_square.sv
module pwr_square #(
    parameter int SAMP_W = 16,
    parameter int PWR_W  = 2 * SAMP_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic                     p_valid,
    output logic [PWR_W-1:0]         p_val
);
    typedef struct packed {
        logic             vld;
        logic [PWR_W-1:0] pwr;
    } sq_state_t;

    sq_state_t st_d, st_q;
    logic signed [2*SAMP_W-1:0] ii, qq;

    always_comb begin
        ii = in_i * in_i;
        qq = in_q * in_q;
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.pwr = PWR_W'($unsigned(ii)) + PWR_W'($unsigned(qq));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign p_valid = st_q.vld;
    assign p_val   = st_q.pwr;
endmodule

// File: rtl/pwr_integrator.sv
module pwr_integrator #(
    parameter int PWR_W = 32,
    parameter int ACC_W = 46,
    parameter int M_W   = 12,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             p_valid,
    input  logic [PWR_W-1:0] p_val,
    input  logic [M_W-1:0]   m_minus1,
    input  logic [SH_W-1:0]  shift,
    output logic             blk_done,
    output logic [ACC_W-1:0] blk_sum,
    output logic [M_W-1:0]   blk_cnt
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [M_W-1:0]   cnt;
    } int_state_t;

    int_state_t st_d, st_q;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] total;
    logic             last;

    always_comb begin
        term  = {{(ACC_W-PWR_W){1'b0}}, (p_val >> shift)};
        total = st_q.acc + term;
        last  = p_valid && (st_q.cnt == m_minus1);
        st_d  = st_q;
        if (clr) begin
            st_d = '0;
        end else if (p_valid) begin
            if (last) begin
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = total;
                st_d.cnt = st_q.cnt + M_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_done = last && !clr;
    assign blk_sum  = total;
    assign blk_cnt  = st_q.cnt;
endmodule

// File: rtl/pwr_block_fifo.sv
module pwr_block_fifo #(
    parameter int ACC_W = 46,
    parameter int N_W   = 2,
    parameter int DEPTH = 1 << N_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [ACC_W-1:0] push_val,
    input  logic [N_W-1:0]   n_minus1,
    output logic             out_valid,
    output logic [ACC_W-1:0] out_sum
);
    typedef struct packed {
        logic [DEPTH-1:0][ACC_W-1:0] ent;
        logic                        vld;
        logic [ACC_W-1:0]            res;
    } hist_state_t;

    hist_state_t st_d, st_q;
    logic [DEPTH-2:0][ACC_W-1:0] masked;
    logic [ACC_W-1:0]            window;

    // entry k joins the window when it is among the newest N-1 stored sums
    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_mask
        assign masked[k] = (N_W'(k) < n_minus1) ? st_q.ent[k] : '0;
    end

    always_comb begin
        window = push_val;
        for (int k = 0; k < DEPTH - 1; k++) begin
            window = window + masked[k];
        end
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (push) begin
            st_d.vld    = 1'b1;
            st_d.res    = window;
            st_d.ent[0] = push_val;
            for (int k = 1; k < DEPTH; k++) begin
                st_d.ent[k] = st_q.ent[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sum   = st_q.res;
endmodule

// File: rtl/pwr_avg_dec.sv
module pwr_avg_dec
    import pwr_avg_pkg::*;
#(
    parameter int SAMP_W = 16,
    localparam int PWR_W = 2 * SAMP_W,
    localparam int ACC_W = PWR_W + CFG_M_W + CFG_N_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic [CFG_M_W-1:0]       cfg_dec_m,
    input  logic [CFG_N_W-1:0]       cfg_avg_n,
    input  logic [CFG_SH_W-1:0]      cfg_shift,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    output logic                     out_valid,
    output logic [ACC_W-1:0]         out_avg
);
    avg_cfg_t cfg_d, cfg_q;

    logic             p_valid;
    logic [PWR_W-1:0] p_val;
    logic             blk_done;
    logic [ACC_W-1:0] blk_sum;
    logic [CFG_M_W-1:0] blk_cnt;

    always_comb begin
        cfg_d = cfg_q;
        if (restart) begin
            cfg_d.m_minus1 = cfg_dec_m;
            cfg_d.n_minus1 = cfg_avg_n;
            cfg_d.shift    = clamp_shift(cfg_shift);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pwr_square #(.SAMP_W(SAMP_W), .PWR_W(PWR_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .clr(restart),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .p_valid(p_valid), .p_val(p_val)
    );

    pwr_integrator #(.PWR_W(PWR_W), .ACC_W(ACC_W), .M_W(CFG_M_W), .SH_W(CFG_SH_W)) u_int (
        .clk(clk), .rst_n(rst_n), .clr(restart),
        .p_valid(p_valid), .p_val(p_val),
        .m_minus1(cfg_q.m_minus1), .shift(cfg_q.shift),
        .blk_done(blk_done), .blk_sum(blk_sum), .blk_cnt(blk_cnt)
    );

    pwr_block_fifo #(.ACC_W(ACC_W), .N_W(CFG_N_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(restart),
        .push(blk_done), .push_val(blk_sum), .n_minus1(cfg_q.n_minus1),
        .out_valid(out_valid), .out_sum(out_avg)
    );
endmodule

// File: rtl/pwr_avg_dec_chk.sv
module pwr_avg_dec_chk #(
    parameter int PWR_W = 32,
    parameter int ACC_W = 46,
    parameter int M_W   = 12,
    parameter int N_W   = 2,
    parameter int SH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             restart,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_avg,
    input logic             blk_done,
    input logic [M_W-1:0]   blk_cnt,
    input logic [M_W-1:0]   cfg_m,
    input logic [N_W-1:0]   cfg_n,
    input logic [SH_W-1:0]  cfg_sh
);
    logic [63:0] lim;
    always_comb begin
        lim = (64'(cfg_n) + 64'd1) * (64'(cfg_m) + 64'd1) * ((64'd1 << (PWR_W - 1)) >> cfg_sh);
    end

    assert_cnt_below_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_cnt <= cfg_m);

    assert_shift_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sh <= SH_W'(14));

    assert_result_from_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(blk_done));

    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (out_valid || $stable(out_avg)));

    assert_restart_quiets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!out_valid && out_avg == '0));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (64'(out_avg) <= lim));
endmodule

bind pwr_avg_dec pwr_avg_dec_chk #(
    .PWR_W(PWR_W), .ACC_W(ACC_W), .M_W(pwr_avg_pkg::CFG_M_W),
    .N_W(pwr_avg_pkg::CFG_N_W), .SH_W(pwr_avg_pkg::CFG_SH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .out_valid(out_valid), .out_avg(out_avg),
    .blk_done(blk_done), .blk_cnt(blk_cnt),
    .cfg_m(cfg_q.m_minus1), .cfg_n(cfg_q.n_minus1), .cfg_sh(cfg_q.shift)
);

// File: tb/pwr_avg_dec_tb_top.sv
module pwr_avg_dec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OUT_W = 46;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic [11:0] cfg_dec_m = '0;
    logic [1:0]  cfg_avg_n = '0;
    logic [3:0]  cfg_shift = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_avg;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_avg_dec dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cfg_dec_m(cfg_dec_m), .cfg_avg_n(cfg_avg_n), .cfg_shift(cfg_shift),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_avg(out_avg)
    );

    // behavioural reference
    int unsigned mdl_m = 1, mdl_n = 1, mdl_sh = 0;
    int unsigned mdl_cnt = 0;
    bit          mdl_pv = 0;
    longint unsigned mdl_p = 0, mdl_acc = 0, mdl_out = 0;
    bit          mdl_ov = 0;
    longint unsigned blocks[$];
    longint unsigned obs[$];

    always @(posedge clk) begin
        if (rst_n) begin
            if (restart) begin
                mdl_m  = int'(cfg_dec_m) + 1;
                mdl_n  = int'(cfg_avg_n) + 1;
                mdl_sh = (cfg_shift > 14) ? 14 : int'(cfg_shift);
                mdl_cnt = 0; mdl_pv = 0; mdl_p = 0; mdl_acc = 0;
                mdl_out = 0; mdl_ov = 0;
                blocks.delete();
            end else begin
                mdl_ov = 0;
                if (mdl_pv) begin
                    mdl_acc += (mdl_p >> mdl_sh);
                    mdl_cnt++;
                    if (mdl_cnt == mdl_m) begin
                        blocks.push_front(mdl_acc);
                        if (blocks.size() > 4) void'(blocks.pop_back());
                        mdl_out = 0;
                        foreach (blocks[k]) if (k < mdl_n) mdl_out += blocks[k];
                        mdl_ov = 1;
                        mdl_acc = 0;
                        mdl_cnt = 0;
                    end
                end
                mdl_pv = in_valid;
                if (in_valid)
                    mdl_p = longint'(in_i) * longint'(in_i) + longint'(in_q) * longint'(in_q);
            end
        end
    end

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R2 R4 R5 R6 R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 out_valid", longint'(out_valid), longint'(mdl_ov));
            check("R5 out_avg", longint'(out_avg), mdl_out);
            if (out_valid) obs.push_back(longint'(out_avg));
        end
    end

    task automatic step(bit v, int i, int q);
        in_valid = v;
        in_i = 16'(i);
        in_q = 16'(q);
        @(negedge clk);
    endtask

    task automatic do_restart(int m1, int n1, int sh, bit v = 0);
        cfg_dec_m = 12'(m1);
        cfg_avg_n = 2'(n1);
        cfg_shift = 4'(sh);
        restart = 1'b1;
        in_valid = v;
        @(negedge clk);
        restart = 1'b0;
        in_valid = 1'b0;
        obs.delete();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_avg", longint'(out_avg), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R9: M=4 N=2 shift 1, I=3 Q=4 (power 25 -> 12), with gaps
        do_restart(3, 1, 1);
        for (int k = 0; k < 12; k++) begin
            step(1, 3, 4);
            if (k % 3 == 1) step(0, 100, 100);
        end
        step(0, 0, 0); step(0, 0, 0);
        check("R3 result count", obs.size(), 3);
        if (obs.size() == 3) begin
            check("R2 first block", obs[0], 48);
            check("R5 partial window", obs[1], 96);
            check("R5 full window", obs[2], 96);
        end

        // R7: settings changed without restart stay inactive
        cfg_dec_m = 12'd0;
        cfg_avg_n = 2'd0;
        obs.delete();
        for (int k = 0; k < 4; k++) step(1, 3, 4);
        step(0, 0, 0); step(0, 0, 0);
        check("R7 no early effect count", obs.size(), 1);
        if (obs.size() == 1) check("R7 no early effect value", obs[0], 96);

        // R7: restart coincides with an offered sample that would end a block
        do_restart(2, 0, 0);
        step(1, 1, 0); step(1, 1, 0);
        do_restart(2, 0, 0, 1);
        for (int k = 0; k < 3; k++) step(1, 2, 0);
        step(0, 0, 0); step(0, 0, 0);
        check("R7 restart count", obs.size(), 1);
        if (obs.size() == 1) check("R7 restart value", obs[0], 12);

        // R4: shift 15 behaves as 14
        do_restart(1, 0, 15);
        step(1, -32768, -32768); step(1, -32768, -32768);
        step(0, 0, 0); step(0, 0, 0);
        check("R4 clamp count", obs.size(), 1);
        if (obs.size() == 1) check("R4 clamp value", obs[0], 64'd262144);

        // R5 R6: M=1000 N=3 shift 12, random samples with gaps
        do_restart(999, 2, 12);
        for (int k = 0; k < 3500; k++) begin
            step(($urandom % 5) != 0, int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768);
        end
        step(0, 0, 0); step(0, 0, 0);

        // R5: M=1 N=4 shift 0, a result every sample
        do_restart(0, 3, 0);
        for (int k = 0; k < 40; k++) step(1, int'($urandom % 65536) - 32768, k);
        step(0, 0, 0); step(0, 0, 0);
        check("R3 M=1 count", obs.size(), 40);

        // R8: full scale, M=4096 N=4 shift 0
        do_restart(4095, 3, 0);
        for (int k = 0; k < 16384; k++) step(1, -32768, -32768);
        step(0, 0, 0); step(0, 0, 0);
        check("R8 count", obs.size(), 4);
        if (obs.size() == 4) begin
            check("R8 first", obs[0], 64'd1 << 43);
            check("R8 full span", obs[3], 64'd1 << 45);
        end

        finish_run();
    end
endmodule